// File: doc/BRIEF.md
# Banked Bit-Addressed Terminal Control Register

This block is the host-facing control register of a display terminal controller. The host changes one flag at a time. Each write carries a 4-bit bit address, a single data bit and a one-cycle strobe. Address 15 holds a bank-select flag. The meaning of addresses 9, 13 and 14 depends on that flag.

The flags cover the following:
- test mode;
- a two-bit test-source select;
- a two-bit self-test character code, passed to the serial transmitter;
- the eighth display data bit, stored next to each character;
- a dual-intensity disable;
- a beep enable.

When test mode is on and the bank flag is set, reading bit address 13 returns one of four internal timing signals. These are video, horizontal sync, vertical sync and audio. This lets software check the display timing through the same bit interface.

Top module: `term_ctrl_reg`

## Requirements
- R1: While rst_ni is low, every stored flag is 0. The outputs bank_o, test_mode_o, st_code_o, attr_bit_o, beep_en_o and rd_data_o are 0, and dual_int_en_o is 1.
- R2: A strobed write to address 15 loads the data bit into the bank flag (bank_o) in the cycle after the strobe, whatever the current bank.
- R3: A strobed write to address 9 loads test mode only while the bank flag is 0. With the bank flag at 1 it leaves test mode unchanged.
- R4: A strobed write to address 13 loads the dual-intensity disable flag only while the bank flag is 0. dual_int_en_o is always the inverse of that flag. With the bank flag at 1 the write has no effect.
- R5: A strobed write to address 14 loads beep_en_o only while the bank flag is 1. With the bank flag at 0 the write has no effect.
- R6: In either bank, addresses 0 and 1 load bit 0 and bit 1 of the test-source select. Addresses 2 and 3 load bit 0 and bit 1 of st_code_o.
- R7: In either bank, address 7 loads attr_bit_o.
- R8: rd_data_o follows the selected source when three conditions hold: rd_addr_i is 13, the bank flag is 1 and test mode is 1. Select 0 picks video_i, 1 picks hsync_i, 2 picks vsync_i and 3 picks audio_i. The path from source to rd_data_o is combinational.
- R9: rd_data_o is 0 in all other cases: a different read address, the bank flag at 0, or test mode off.
- R10: Nothing changes without wr_stb_i. A strobed write to addresses 4, 5, 6, 8, 10, 11 or 12 changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_stb_i | input | 1 | One-cycle write strobe |
| wr_addr_i | input | 4 | Bit address of the write |
| wr_data_i | input | 1 | Value written to the addressed flag |
| rd_addr_i | input | 4 | Bit address being read |
| video_i | input | 1 | Test source, select 0 |
| hsync_i | input | 1 | Test source, select 1 |
| vsync_i | input | 1 | Test source, select 2 |
| audio_i | input | 1 | Test source, select 3 |
| rd_data_o | output | 1 | Read bit |
| bank_o | output | 1 | Bank-select flag |
| test_mode_o | output | 1 | Test mode flag |
| st_code_o | output | 2 | Self-test character code |
| attr_bit_o | output | 1 | Eighth display data bit |
| dual_int_en_o | output | 1 | Dual intensity enabled |
| beep_en_o | output | 1 | Beep enable |

## Verification
The assertions assume the write inputs are driven to known values whenever the strobe is high. They also assume the timing sources and read address are known. The banked-write properties sample the bank flag in the same cycle as the strobe. This only makes sense if the host never changes bank and writes a banked address in the same cycle. The write port allows just one write per cycle, so this always holds. The stimulus drives every input between clock edges and holds it steady across the edge. It never strobes without a defined address and data bit.

// File: rtl/term_ctrl_pkg.sv
package term_ctrl_pkg;
  localparam int ADDR_W = 4;
  localparam int SEL_W  = 2;
  localparam int N_SRC  = 1 << SEL_W;

  localparam logic [ADDR_W-1:0] A_SEL0  = 4'd0;
  localparam logic [ADDR_W-1:0] A_SEL1  = 4'd1;
  localparam logic [ADDR_W-1:0] A_CODE0 = 4'd2;
  localparam logic [ADDR_W-1:0] A_CODE1 = 4'd3;
  localparam logic [ADDR_W-1:0] A_ATTR  = 4'd7;
  localparam logic [ADDR_W-1:0] A_TEST  = 4'd9;
  localparam logic [ADDR_W-1:0] A_DIS   = 4'd13;
  localparam logic [ADDR_W-1:0] A_BEEP  = 4'd14;
  localparam logic [ADDR_W-1:0] A_BANK  = 4'd15;
  localparam logic [ADDR_W-1:0] A_TRD   = 4'd13;

  typedef struct packed {
    logic             bank;
    logic             test_mode;
    logic [SEL_W-1:0] sel;
    logic [1:0]       code;
    logic             attr;
    logic             dual_dis;
    logic             beep;
  } flags_t;

  localparam int FLAG_W = $bits(flags_t);
endpackage

// File: rtl/term_wr_decode.sv
module term_wr_decode
  import term_ctrl_pkg::*;
(
  input  logic              stb_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              bank_i,
  output flags_t            we_o
);
  always_comb begin
    we_o = '0;
    if (stb_i) begin
      unique case (addr_i)
        A_SEL0:  we_o.sel[0]    = 1'b1;
        A_SEL1:  we_o.sel[1]    = 1'b1;
        A_CODE0: we_o.code[0]   = 1'b1;
        A_CODE1: we_o.code[1]   = 1'b1;
        A_ATTR:  we_o.attr      = 1'b1;
        A_TEST:  we_o.test_mode = !bank_i;
        A_DIS:   we_o.dual_dis  = !bank_i;
        A_BEEP:  we_o.beep      = bank_i;
        A_BANK:  we_o.bank      = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/term_flag_reg.sv
module term_flag_reg
  import term_ctrl_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  flags_t we_i,
  input  logic   data_i,
  output flags_t flags_o
);
  logic [FLAG_W-1:0] q;
  logic [FLAG_W-1:0] we_v;

  assign we_v    = we_i;
  assign flags_o = q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= (q & ~we_v) | (we_v & {FLAG_W{data_i}});
  end
endmodule

// File: rtl/term_test_mux.sv
module term_test_mux
  import term_ctrl_pkg::*;
(
  input  logic [N_SRC-1:0] src_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             en_i,
  output logic             rd_o
);
  logic [N_SRC-1:0] hit;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign hit[i] = (sel_i == SEL_W'(i)) & src_i[i];
  end

  assign rd_o = en_i & (|hit);
endmodule

// File: rtl/term_ctrl_reg.sv
module term_ctrl_reg
  import term_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_stb_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              video_i,
  input  logic              hsync_i,
  input  logic              vsync_i,
  input  logic              audio_i,
  output logic              rd_data_o,
  output logic              bank_o,
  output logic              test_mode_o,
  output logic [1:0]        st_code_o,
  output logic              attr_bit_o,
  output logic              dual_int_en_o,
  output logic              beep_en_o
);
  flags_t flags;
  flags_t we;
  logic   rd_en;

  term_wr_decode u_dec (
    .stb_i (wr_stb_i),
    .addr_i(wr_addr_i),
    .bank_i(flags.bank),
    .we_o  (we)
  );

  term_flag_reg u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we),
    .data_i (wr_data_i),
    .flags_o(flags)
  );

  assign rd_en = (rd_addr_i == A_TRD) & flags.bank & flags.test_mode;

  term_test_mux u_mux (
    .src_i({audio_i, vsync_i, hsync_i, video_i}),
    .sel_i(flags.sel),
    .en_i (rd_en),
    .rd_o (rd_data_o)
  );

  assign bank_o        = flags.bank;
  assign test_mode_o   = flags.test_mode;
  assign st_code_o     = flags.code;
  assign attr_bit_o    = flags.attr;
  assign dual_int_en_o = !flags.dual_dis;
  assign beep_en_o     = flags.beep;

  // R2
  bank_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_i && wr_addr_i == A_BANK) |=> (bank_o == $past(wr_data_i)));

  // R3
  test_bank1_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_i && wr_addr_i == A_TEST && bank_o) |=> $stable(test_mode_o));

  // R4
  dis_bank1_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_i && wr_addr_i == A_DIS && bank_o) |=> $stable(dual_int_en_o));

  // R5
  beep_bank0_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_i && wr_addr_i == A_BEEP && !bank_o) |=> $stable(beep_en_o));

  // R9
  rd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i != A_TRD || !bank_o || !test_mode_o) |-> !rd_data_o);

  // R10
  no_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stb_i |=> ($stable(bank_o) && $stable(test_mode_o) && $stable(st_code_o)
                   && $stable(attr_bit_o) && $stable(dual_int_en_o) && $stable(beep_en_o)));
endmodule

// File: tb/term_ctrl_reg_bench.sv
module term_ctrl_reg_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_stb = 1'b0;
  logic [3:0] wr_addr = '0;
  logic       wr_data = 1'b0;
  logic [3:0] rd_addr = '0;
  logic [3:0] src = '0;
  logic       rd_data, bank, tm, attr, dual_en, beep;
  logic [1:0] code;

  always #(CLK_PERIOD/2) clk = ~clk;

  term_ctrl_reg u_term_ctrl_reg (
    .clk_i(clk), .rst_ni(rst_ni), .wr_stb_i(wr_stb), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .video_i(src[0]), .hsync_i(src[1]), .vsync_i(src[2]), .audio_i(src[3]),
    .rd_data_o(rd_data), .bank_o(bank), .test_mode_o(tm), .st_code_o(code),
    .attr_bit_o(attr), .dual_int_en_o(dual_en), .beep_en_o(beep)
  );

  typedef struct {
    logic [7:0] exp;
    string      req;
  } item_t;

  item_t q[$];
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 0;

  logic       m_bank = 0, m_tm = 0, m_attr = 0, m_dis = 0, m_beep = 0;
  logic [1:0] m_sel = 0, m_code = 0;

  function automatic logic [7:0] act_vec();
    return {bank, tm, code, attr, dual_en, beep, rd_data};
  endfunction

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        logic [7:0] a;
        it = q.pop_front();
        a = act_vec();
        n_chk++;
        if (a !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %b expected %b {bank,tm,code,attr,dual_en,beep,rd}",
                   it.req, a, it.exp);
        end
      end
    end
  end

  task automatic do_write(input logic [3:0] a, input logic d);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
    case (a)
      4'd0:  m_sel[0] = d;
      4'd1:  m_sel[1] = d;
      4'd2:  m_code[0] = d;
      4'd3:  m_code[1] = d;
      4'd7:  m_attr = d;
      4'd9:  if (!m_bank) m_tm = d;
      4'd13: if (!m_bank) m_dis = d;
      4'd14: if (m_bank) m_beep = d;
      4'd15: m_bank = d;
      default: ;
    endcase
  endtask

  task automatic probe(input logic [3:0] a, input string req);
    item_t it;
    logic r;
    @(negedge clk);
    rd_addr = a;
    r = (a == 4'd13 && m_bank && m_tm) ? src[m_sel] : 1'b0;
    it.exp = {m_bank, m_tm, m_code, m_attr, !m_dis, m_beep, r};
    it.req = req;
    @(posedge clk);
    q.push_back(it);
    while (q.size() != 0) @(negedge clk);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    probe(4'd0, "R1");
    rst_ni = 1'b1;
    probe(4'd13, "R1");

    do_write(4'd14, 1'b1);  probe(4'd0, "R5");    // bank 0: beep ignored
    do_write(4'd9, 1'b1);   probe(4'd0, "R3");
    do_write(4'd13, 1'b1);  probe(4'd0, "R4");
    do_write(4'd2, 1'b1);   probe(4'd0, "R6");
    do_write(4'd3, 1'b1);   probe(4'd0, "R6");
    do_write(4'd2, 1'b0);   probe(4'd0, "R6");
    do_write(4'd7, 1'b1);   probe(4'd0, "R7");
    src = 4'hF;
    probe(4'd13, "R9");                           // bank 0 blocks readback

    for (int a = 4; a <= 12; a++) begin
      if (a == 7 || a == 9) continue;
      do_write(4'(a), 1'b1);
    end
    probe(4'd0, "R10");
    @(negedge clk); wr_addr = 4'd15; wr_data = 1'b1;
    @(negedge clk); @(negedge clk); wr_data = 1'b0;
    probe(4'd0, "R10");                           // no strobe, no bank change

    do_write(4'd15, 1'b1);  probe(4'd0, "R2");
    probe(4'd9, "R9");

    for (int s = 0; s < 4; s++) begin
      do_write(4'd0, s[0]);
      do_write(4'd1, s[1]);
      src = 4'b0001 << s;
      probe(4'd13, "R8");
      src = ~(4'b0001 << s);
      probe(4'd13, "R8");
    end

    do_write(4'd9, 1'b0);   probe(4'd13, "R3");   // bank 1: test mode kept
    do_write(4'd13, 1'b0);  probe(4'd0, "R4");    // bank 1: disable kept
    do_write(4'd14, 1'b1);  probe(4'd0, "R5");
    do_write(4'd7, 1'b0);   probe(4'd0, "R7");

    do_write(4'd15, 1'b0);  probe(4'd0, "R2");
    do_write(4'd9, 1'b0);   probe(4'd0, "R3");
    do_write(4'd13, 1'b0);  probe(4'd0, "R4");
    do_write(4'd15, 1'b1);  probe(4'd13, "R9");   // test mode off

    rst_ni = 1'b0;
    m_bank = 0; m_tm = 0; m_attr = 0; m_dis = 0; m_beep = 0; m_sel = 0; m_code = 0;
    probe(4'd13, "R1");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule